// File: doc/BRIEF.md
# CAN Receive-Path Mode Controller

This block sits between a CAN protocol engine and the receive message buffers. It adds two special modes to the receive path. The first is a silent self-test mode. In this mode the engine's serial transmit stream is routed straight back to the engine's receive input. The transmit pin is held recessive and handed back to general-purpose I/O, and the engine is told to ignore a missing acknowledge. A node in this mode therefore receives its own frames without touching the bus. Switching into or out of the mode takes effect only while the engine reports idle. A request made in the middle of a frame waits until the engine is idle.

Each receive buffer has a 2-bit mode field. A buffer set to 11 accepts every frame whatever its identifier. When the engine raises an error strobe, the lowest-numbered such buffer is loaded with the partly assembled frame. At the same time, a diagnostic snapshot stores the bus bit the engine sampled, the engine's state vector and its bit counter. The snapshot stays fixed until the host clears it. A buffer with any other mode value loads only frames whose identifiers pass its mask and filter. Of all the buffers that accept a frame, the lowest-numbered one gets it.

Top module: `can_rx_mode_ctrl`

## Requirements
- R1: `lpbk_active` changes only on a clock edge where `eng_idle` was high. A level on `lpbk_req` that arrives while the engine is busy is held and takes effect at the first idle edge.
- R2: While `lpbk_active` is high, `can_tx` stays at 1 (recessive) for any value of `tx_bit`.
- R3: `tx_pin_gpio` is high exactly while `lpbk_active` is high. Outside self-test mode, `can_tx` equals `tx_bit`.
- R4: `eng_rx_bit` equals `tx_bit` in self-test mode and `can_rx` otherwise. In self-test mode the value of `can_rx` has no effect.
- R5: `ack_ignore` is high exactly while self-test mode is active.
- R6: A buffer whose mode field is not 11 accepts an identifier when `((frame_id ^ filt) & mask) == 0`. The same filtering applies in self-test mode.
- R7: A buffer with an all-zero mask accepts every identifier.
- R8: A buffer whose mode field is 11 accepts every identifier.
- R9: One cycle after `frame_done`, `buf_load` holds a single bit set, for the lowest-indexed accepting buffer. It is all zeros if no buffer accepts. `load_id` and `load_data` carry the frame at that point.
- R10: When `err_strobe` is high and at least one buffer has mode 11, then one cycle later the lowest such buffer is loaded with `asm_data` and `load_err` is 1. An error cycle discards a `frame_done` in the same cycle. When no buffer has mode 11, an error loads nothing.
- R11: An error that loads a buffer while no snapshot is held sets `snap_valid` and captures `eng_rx_bit`, `eng_state` and `bit_cnt` at that edge.
- R12: While `snap_valid` is high, later errors leave the snapshot unchanged. `snap_clr` drops `snap_valid`, but an error that arrives in the same cycle as the clear is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lpbk_req | input | 1 | Requested self-test mode level |
| eng_idle | input | 1 | Protocol engine is between frames |
| rx_mode | input | 2*NBUF | Mode field per buffer; buffer i at [2i+1:2i] |
| acc_mask | input | ID_W*NBUF | Acceptance mask per buffer |
| acc_filt | input | ID_W*NBUF | Acceptance filter per buffer |
| tx_bit | input | 1 | Serial transmit stream from engine |
| can_rx | input | 1 | Bus receive line |
| can_tx | output | 1 | Transmit pin drive |
| tx_pin_gpio | output | 1 | Transmit pin released to port I/O |
| eng_rx_bit | output | 1 | Receive bit presented to engine |
| ack_ignore | output | 1 | Engine may ignore a missing acknowledge |
| lpbk_active | output | 1 | Self-test mode in force |
| frame_done | input | 1 | Complete frame strobe |
| frame_id | input | ID_W | Identifier of current frame |
| asm_data | input | DATA_W | Assembly buffer contents |
| err_strobe | input | 1 | Protocol error strobe |
| eng_state | input | STATE_W | Engine state vector |
| bit_cnt | input | CNT_W | Engine bit counter |
| buf_load | output | NBUF | One-hot buffer load strobe |
| load_id | output | ID_W | Identifier written with the load |
| load_data | output | DATA_W | Data written with the load |
| load_err | output | 1 | Load is a partial frame after an error |
| snap_clr | input | 1 | Host clears the snapshot |
| snap_valid | output | 1 | Snapshot held |
| snap_bus_bit | output | 1 | Captured sampled bus bit |
| snap_state | output | STATE_W | Captured engine state |
| snap_cnt | output | CNT_W | Captured bit counter |

## Verification
Two events can land on the same edge. In the first, a frame-complete strobe and an error strobe rise together. The bench drives both while one buffer's filter matches the identifier and another buffer is in mode 11. It passes only if the mode-11 buffer is loaded, with the error marker set, and the filtered buffer is not. In the second, a snapshot clear and a new error arrive together. This must leave a valid snapshot that holds the new state vector and bit count, not the old ones.

// File: rtl/can_rxm_pkg.sv
// Package: shared encodings for the receive-path mode controller.
// Assumes the per-buffer mode field is two bits wide.
package can_rxm_pkg;
    typedef enum logic [1:0] {
        RXM_FILT_A = 2'b00,
        RXM_FILT_B = 2'b01,
        RXM_FILT_C = 2'b10,
        RXM_ERRREC = 2'b11
    } rxm_e;

    localparam logic BIT_RECESSIVE = 1'b1;
endpackage

// File: rtl/can_rxm_modesel.sv
// Self-test mode keeper and pin multiplexer.
// Changes mode only on an idle edge. In self-test mode the transmit
// pin is held recessive and released to port I/O, and the engine
// hears its own transmit stream.
module can_rxm_modesel
    import can_rxm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lpbk_req,
    input  logic eng_idle,
    input  logic tx_bit,
    input  logic can_rx,
    output logic can_tx,
    output logic tx_pin_gpio,
    output logic eng_rx_bit,
    output logic ack_ignore,
    output logic lpbk_active
);
    logic lpbk_q;

    // Mode register: follows the request level only while the engine is idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lpbk_q <= 1'b0;
        else if (eng_idle)
            lpbk_q <= lpbk_req;
    end

    // Pin and receive-path steering.
    always_comb begin
        can_tx      = lpbk_q ? BIT_RECESSIVE : tx_bit;
        tx_pin_gpio = lpbk_q;
        eng_rx_bit  = lpbk_q ? tx_bit : can_rx;
        ack_ignore  = lpbk_q;
        lpbk_active = lpbk_q;
    end

    p_mode_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (lpbk_q != $past(lpbk_q)) |-> $past(eng_idle));

    p_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lpbk_active |-> (can_tx == BIT_RECESSIVE));
endmodule

// File: rtl/can_rxm_accept.sv
// Per-buffer acceptance test.
// A buffer in mode 11 takes any identifier; every other mode compares
// the identifier with the buffer's filter under its mask.
// Mask/filter of buffer i sit at [ID_W*i +: ID_W].
module can_rxm_accept
    import can_rxm_pkg::*;
#(
    parameter int NBUF = 2,
    parameter int ID_W = 11
) (
    input  logic [2*NBUF-1:0]    rx_mode,
    input  logic [ID_W*NBUF-1:0] acc_mask,
    input  logic [ID_W*NBUF-1:0] acc_filt,
    input  logic [ID_W-1:0]      frame_id,
    output logic [NBUF-1:0]      accept_vec,
    output logic [NBUF-1:0]      erm_vec
);
    for (genvar gi = 0; gi < NBUF; gi++) begin : g_buf
        logic [ID_W-1:0] diff;
        // Masked identifier comparison and mode decode for one buffer.
        always_comb begin
            erm_vec[gi]    = (rxm_e'(rx_mode[2*gi +: 2]) == RXM_ERRREC);
            diff           = (frame_id ^ acc_filt[ID_W*gi +: ID_W]) & acc_mask[ID_W*gi +: ID_W];
            accept_vec[gi] = erm_vec[gi] || (diff == '0);
        end
    end

    p_erm_accepts_r8: assert final ((erm_vec & ~accept_vec) == '0);
endmodule

// File: rtl/can_rxm_snap.sv
// Error snapshot register set.
// Captures bus bit, state vector and bit counter when an error loads a
// buffer and no unread snapshot is held. The host clears it with a
// pulse; a capture in the clear cycle is kept.
module can_rxm_snap #(
    parameter int STATE_W = 5,
    parameter int CNT_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               err_hit,
    input  logic               snap_clr,
    input  logic               bus_bit,
    input  logic [STATE_W-1:0] eng_state,
    input  logic [CNT_W-1:0]   bit_cnt,
    output logic               snap_valid,
    output logic               snap_bus_bit,
    output logic [STATE_W-1:0] snap_state,
    output logic [CNT_W-1:0]   snap_cnt
);
    logic cap_ok;

    // A capture is allowed when the slot is empty or being emptied now.
    always_comb cap_ok = err_hit && (!snap_valid || snap_clr);

    // Snapshot storage with hold-until-cleared behaviour.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_valid   <= 1'b0;
            snap_bus_bit <= 1'b0;
            snap_state   <= '0;
            snap_cnt     <= '0;
        end else if (cap_ok) begin
            snap_valid   <= 1'b1;
            snap_bus_bit <= bus_bit;
            snap_state   <= eng_state;
            snap_cnt     <= bit_cnt;
        end else if (snap_clr) begin
            snap_valid   <= 1'b0;
        end
    end

    p_snap_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_valid && !snap_clr) |=>
            (snap_valid && $stable(snap_state) && $stable(snap_cnt) && $stable(snap_bus_bit)));

    p_snap_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(snap_valid) |-> $past(err_hit));
endmodule

// File: rtl/can_rx_mode_ctrl.sv
// Top: receive-path mode controller.
// Combines the self-test mode keeper, per-buffer acceptance and the
// error snapshot. Picks the lowest-indexed buffer and registers one
// load strobe per frame or error. An error cycle takes precedence over
// a coincident frame_done.
module can_rx_mode_ctrl
    import can_rxm_pkg::*;
#(
    parameter int NBUF    = 2,
    parameter int ID_W    = 11,
    parameter int DATA_W  = 64,
    parameter int STATE_W = 5,
    parameter int CNT_W   = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lpbk_req,
    input  logic                 eng_idle,
    input  logic [2*NBUF-1:0]    rx_mode,
    input  logic [ID_W*NBUF-1:0] acc_mask,
    input  logic [ID_W*NBUF-1:0] acc_filt,
    input  logic                 tx_bit,
    input  logic                 can_rx,
    output logic                 can_tx,
    output logic                 tx_pin_gpio,
    output logic                 eng_rx_bit,
    output logic                 ack_ignore,
    output logic                 lpbk_active,
    input  logic                 frame_done,
    input  logic [ID_W-1:0]      frame_id,
    input  logic [DATA_W-1:0]    asm_data,
    input  logic                 err_strobe,
    input  logic [STATE_W-1:0]   eng_state,
    input  logic [CNT_W-1:0]     bit_cnt,
    output logic [NBUF-1:0]      buf_load,
    output logic [ID_W-1:0]      load_id,
    output logic [DATA_W-1:0]    load_data,
    output logic                 load_err,
    input  logic                 snap_clr,
    output logic                 snap_valid,
    output logic                 snap_bus_bit,
    output logic [STATE_W-1:0]   snap_state,
    output logic [CNT_W-1:0]     snap_cnt
);
    localparam logic [NBUF-1:0] ONE = {{(NBUF-1){1'b0}}, 1'b1};

    logic [NBUF-1:0] accept_vec, erm_vec, pick_acc, pick_erm;
    logic            err_hit;

    can_rxm_modesel i_modesel (
        .clk         (clk),
        .rst_n       (rst_n),
        .lpbk_req    (lpbk_req),
        .eng_idle    (eng_idle),
        .tx_bit      (tx_bit),
        .can_rx      (can_rx),
        .can_tx      (can_tx),
        .tx_pin_gpio (tx_pin_gpio),
        .eng_rx_bit  (eng_rx_bit),
        .ack_ignore  (ack_ignore),
        .lpbk_active (lpbk_active)
    );

    can_rxm_accept #(.NBUF(NBUF), .ID_W(ID_W)) i_accept (
        .rx_mode    (rx_mode),
        .acc_mask   (acc_mask),
        .acc_filt   (acc_filt),
        .frame_id   (frame_id),
        .accept_vec (accept_vec),
        .erm_vec    (erm_vec)
    );

    // Lowest-set-bit isolation gives index priority; error only counts with a mode-11 buffer.
    always_comb begin
        pick_acc = accept_vec & (~accept_vec + ONE);
        pick_erm = erm_vec & (~erm_vec + ONE);
        err_hit  = err_strobe && (erm_vec != '0);
    end

    // Load strobe and payload register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_load  <= '0;
            load_id   <= '0;
            load_data <= '0;
            load_err  <= 1'b0;
        end else begin
            buf_load <= '0;
            load_err <= 1'b0;
            if (err_hit) begin
                buf_load  <= pick_erm;
                load_err  <= 1'b1;
                load_id   <= frame_id;
                load_data <= asm_data;
            end else if (frame_done && !err_strobe && accept_vec != '0) begin
                buf_load  <= pick_acc;
                load_id   <= frame_id;
                load_data <= asm_data;
            end
        end
    end

    can_rxm_snap #(.STATE_W(STATE_W), .CNT_W(CNT_W)) i_snap (
        .clk          (clk),
        .rst_n        (rst_n),
        .err_hit      (err_hit),
        .snap_clr     (snap_clr),
        .bus_bit      (eng_rx_bit),
        .eng_state    (eng_state),
        .bit_cnt      (bit_cnt),
        .snap_valid   (snap_valid),
        .snap_bus_bit (snap_bus_bit),
        .snap_state   (snap_state),
        .snap_cnt     (snap_cnt)
    );

    p_onehot_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(buf_load));

    p_err_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |-> ($past(err_strobe) && $countones(buf_load) == 1));
endmodule

// File: tb/test_can_rx_mode_ctrl.sv
`timescale 1ns/1ps
module test_can_rx_mode_ctrl;
    localparam int NBUF = 2, ID_W = 11, DATA_W = 64, STATE_W = 5, CNT_W = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lpbk_req = 1'b0, eng_idle = 1'b1, tx_bit = 1'b1, can_rx = 1'b1;
    logic [2*NBUF-1:0] rx_mode = '0;
    logic [ID_W*NBUF-1:0] acc_mask = '0, acc_filt = '0;
    logic frame_done = 1'b0, err_strobe = 1'b0, snap_clr = 1'b0;
    logic [ID_W-1:0] frame_id = '0;
    logic [DATA_W-1:0] asm_data = '0;
    logic [STATE_W-1:0] eng_state = '0;
    logic [CNT_W-1:0] bit_cnt = '0;
    logic can_tx, tx_pin_gpio, eng_rx_bit, ack_ignore, lpbk_active;
    logic [NBUF-1:0] buf_load;
    logic [ID_W-1:0] load_id;
    logic [DATA_W-1:0] load_data;
    logic load_err, snap_valid, snap_bus_bit;
    logic [STATE_W-1:0] snap_state;
    logic [CNT_W-1:0] snap_cnt;

    int errors = 0, checks = 0, cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    can_rx_mode_ctrl #(.NBUF(NBUF), .ID_W(ID_W), .DATA_W(DATA_W),
                       .STATE_W(STATE_W), .CNT_W(CNT_W)) i_can_rx_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .lpbk_req(lpbk_req), .eng_idle(eng_idle),
        .rx_mode(rx_mode), .acc_mask(acc_mask), .acc_filt(acc_filt),
        .tx_bit(tx_bit), .can_rx(can_rx), .can_tx(can_tx),
        .tx_pin_gpio(tx_pin_gpio), .eng_rx_bit(eng_rx_bit),
        .ack_ignore(ack_ignore), .lpbk_active(lpbk_active),
        .frame_done(frame_done), .frame_id(frame_id), .asm_data(asm_data),
        .err_strobe(err_strobe), .eng_state(eng_state), .bit_cnt(bit_cnt),
        .buf_load(buf_load), .load_id(load_id), .load_data(load_data),
        .load_err(load_err), .snap_clr(snap_clr), .snap_valid(snap_valid),
        .snap_bus_bit(snap_bus_bit), .snap_state(snap_state), .snap_cnt(snap_cnt)
    );

    typedef struct packed {
        logic [3:0]  modes;
        logic [10:0] m0, f0, m1, f1, id;
        logic        fd, err;
        logic [1:0]  exp_load;
        logic        exp_err;
    } vec_t;

    localparam vec_t TBL [0:9] = '{
        '{4'b0000, 11'h7FF, 11'h123, 11'h7FF, 11'h456, 11'h123, 1'b1, 1'b0, 2'b01, 1'b0}, // R6 match b0
        '{4'b0000, 11'h7FF, 11'h123, 11'h7FF, 11'h456, 11'h456, 1'b1, 1'b0, 2'b10, 1'b0}, // R6 match b1
        '{4'b0000, 11'h7FF, 11'h123, 11'h7FF, 11'h456, 11'h124, 1'b1, 1'b0, 2'b00, 1'b0}, // R6 no match
        '{4'b0000, 11'h000, 11'h123, 11'h7FF, 11'h456, 11'h7AA, 1'b1, 1'b0, 2'b01, 1'b0}, // R7 zero mask
        '{4'b1100, 11'h7FF, 11'h123, 11'h7FF, 11'h456, 11'h055, 1'b1, 1'b0, 2'b10, 1'b0}, // R8 mode 11
        '{4'b1111, 11'h7FF, 11'h123, 11'h7FF, 11'h456, 11'h055, 1'b1, 1'b0, 2'b01, 1'b0}, // R9 priority
        '{4'b1100, 11'h7FF, 11'h123, 11'h7FF, 11'h456, 11'h055, 1'b0, 1'b1, 2'b10, 1'b1}, // R10 error load
        '{4'b0000, 11'h7FF, 11'h123, 11'h7FF, 11'h456, 11'h055, 1'b0, 1'b1, 2'b00, 1'b0}, // R10 no mode 11
        '{4'b1100, 11'h7FF, 11'h123, 11'h7FF, 11'h456, 11'h123, 1'b1, 1'b1, 2'b10, 1'b1}, // R10 coincident
        '{4'b0000, 11'h000, 11'h123, 11'h000, 11'h456, 11'h300, 1'b1, 1'b0, 2'b01, 1'b0}  // R9 both accept
    };

    function automatic string row_req(int i);
        case (i)
            0, 1, 2: return "R6";
            3:       return "R7";
            4:       return "R8";
            5, 9:    return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive strobes for one cycle, then land on the following negedge.
    task automatic pulse(logic fd, logic er, logic clr);
        @(negedge clk);
        frame_done = fd; err_strobe = er; snap_clr = clr;
        @(negedge clk);
        frame_done = 1'b0; err_strobe = 1'b0; snap_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000 && !done) begin
                checks++; errors++;
                $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check("R3 reset gpio", tx_pin_gpio, 0);
        check("R5 reset ack_ignore", ack_ignore, 0);
        check("R9 reset buf_load", buf_load, 0);
        check("R11 reset snap_valid", snap_valid, 0);

        // Table walk
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            rx_mode  = TBL[i].modes;
            acc_mask = {TBL[i].m1, TBL[i].m0};
            acc_filt = {TBL[i].f1, TBL[i].f0};
            frame_id = TBL[i].id;
            asm_data = 64'hA5A5_0000_0000_0000 | 64'(i);
            pulse(TBL[i].fd, TBL[i].err, 1'b0);
            check(row_req(i), buf_load, TBL[i].exp_load);
            check(row_req(i), load_err, TBL[i].exp_err);
            if (TBL[i].exp_load != 0)
                check(row_req(i), load_id, TBL[i].id);
        end

        // Snapshot capture (R11)
        pulse(1'b0, 1'b0, 1'b1);
        check("R12 clear", snap_valid, 0);
        rx_mode = 4'b1100; eng_state = 5'h13; bit_cnt = 7'h2A; can_rx = 1'b0;
        asm_data = 64'h0123_4567_89AB_CDEF;
        pulse(1'b0, 1'b1, 1'b0);
        check("R11 valid", snap_valid, 1);
        check("R11 state", snap_state, 5'h13);
        check("R11 count", snap_cnt, 7'h2A);
        check("R11 bus bit", snap_bus_bit, 0);
        check("R10 partial data", load_data, 64'h0123_4567_89AB_CDEF);
        // Unread snapshot is kept (R12)
        eng_state = 5'h07; bit_cnt = 7'h11; can_rx = 1'b1;
        pulse(1'b0, 1'b1, 1'b0);
        check("R12 hold state", snap_state, 5'h13);
        check("R12 hold count", snap_cnt, 7'h2A);
        // Clear and error together: new capture kept (R12)
        pulse(1'b0, 1'b1, 1'b1);
        check("R12 clr+err valid", snap_valid, 1);
        check("R12 clr+err state", snap_state, 5'h07);
        check("R12 clr+err count", snap_cnt, 7'h11);
        pulse(1'b0, 1'b0, 1'b1);
        check("R12 clear again", snap_valid, 0);
        // Error with no mode-11 buffer captures nothing (R10)
        rx_mode = 4'b0000;
        pulse(1'b0, 1'b1, 1'b0);
        check("R10 no capture", snap_valid, 0);
        check("R10 no load", buf_load, 0);

        // Normal mode pin path (R3, R4)
        tx_bit = 1'b0; can_rx = 1'b1;
        @(negedge clk);
        check("R3 can_tx follows", can_tx, 0);
        check("R4 rx from bus", eng_rx_bit, 1);

        // Request while busy is held (R1)
        eng_idle = 1'b0; lpbk_req = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 held while busy", lpbk_active, 0);
        check("R3 gpio still 0", tx_pin_gpio, 0);
        eng_idle = 1'b1;
        @(negedge clk);
        check("R1 enter at idle", lpbk_active, 1);
        check("R3 gpio released", tx_pin_gpio, 1);
        check("R5 ack ignored", ack_ignore, 1);
        check("R2 silent with tx 0", can_tx, 1);
        check("R4 self rx 0", eng_rx_bit, 0);
        tx_bit = 1'b1; can_rx = 1'b0;
        @(negedge clk);
        check("R4 self rx 1 bus ignored", eng_rx_bit, 1);

        // Filtering still applies in self-test mode (R6)
        acc_mask = {11'h7FF, 11'h7FF}; acc_filt = {11'h456, 11'h123};
        frame_id = 11'h124;
        pulse(1'b1, 1'b0, 1'b0);
        check("R6 loopback reject", buf_load, 2'b00);
        frame_id = 11'h123;
        pulse(1'b1, 1'b0, 1'b0);
        check("R6 loopback accept", buf_load, 2'b01);

        // Leaving also waits for idle (R1)
        eng_idle = 1'b0; lpbk_req = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 exit held", lpbk_active, 1);
        eng_idle = 1'b1;
        @(negedge clk);
        check("R1 exit at idle", lpbk_active, 0);

        done = 1'b1;
        finish_run();
    end
endmodule